// File: doc/BRIEF.md
# Display RAM slot arbiter

This block lets a processor and a display refresh engine share one single-port video RAM of 9600 sixteen-bit words, which is 19200 bytes. While a line is being sent to the panel, the RAM clock ticks are split into fixed pairs. The even tick of each pair serves the processor and the odd tick serves the display fetch. A processor access that lands in this window pulls `wait_n` low until its data is ready. During horizontal blanking the display takes no ticks, so the processor is served on the first tick it presents a request and never sees a wait.

The processor side accepts a chip select, a read strobe and two write strobes, with byte addresses up to 15 bits. In narrow (8-bit) mode each access moves one byte. In wide (16-bit) mode byte lanes are chosen in one of two ways: by address bit 0 together with a bus-high enable, or by separate low and high write strobes. A swap input reverses the byte order on the data bus. The display side gives a word offset and a flag that selects the upper screen of a dual-scan panel. The block drives the shared RAM port and returns the fetched word one tick later.

Top module: `vram_slot_arbiter`

## Requirements
- R1: After reset `wait_n` is 1, `cse` is 0, `ram_en` is 0 and `dout` is 0.
- R2: While `disp_active` is 1, the ticks alternate between processor and display, and the first tick after reset is a processor tick. On each display tick `cse` is 1, `ram_en` is 1, `ram_we` is 00 and `ram_addr` is the display address. On processor ticks `cse` is 0.
- R3: During active display, a request that first appears before a display tick is held and served on the processor tick that follows it, with `ram_addr` equal to byte address bits 14:1.
- R4: During active display, `wait_n` is 0 from the moment a valid request appears until the access has completed. For a read, completion means the read data is on `dout`.
- R5: While `disp_active` is 0, a request is served on the first tick and `wait_n` stays 1.
- R6: Byte addresses above 4AFFh write nothing, read as 0 and never pull `wait_n` low. Address 4AFFh is still stored and read back.
- R7: In narrow mode (`wide`=0), even byte addresses map to RAM bits 7:0 and odd byte addresses map to RAM bits 15:8. Data moves on `wdata[7:0]` and `dout[7:0]`, and `dout[15:8]` is 0.
- R8: In wide mode with `strobe_lanes`=0, the low write strobe writes the lower lane when address bit 0 is 0 and the upper lane when `bhe_n` is 0.
- R9: In wide mode with `strobe_lanes`=1, `lwr_n` writes the lower lane and `hwr_n` writes the upper lane, each on its own.
- R10: In wide mode, `swap`=0 puts the lower lane on bus bits 7:0 and `swap`=1 puts it on bus bits 15:8. This applies to both writes and reads.
- R11: When `disp_upper` is 1, the display word address is `disp_word` plus 4800, so word 0 of the upper screen is byte 2580h.
- R12: Read data stays on `dout` for as long as the read is held, and `dout` is 0 once `rd_n` or `mcs_n` is released.
- R13: `disp_valid` is 1 on the tick after a display tick, and `disp_data` then carries the word stored at the fetched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RAM tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcs_n | input | 1 | RAM select from the processor, active low |
| rd_n | input | 1 | Read strobe, active low |
| lwr_n | input | 1 | Low write strobe, active low |
| hwr_n | input | 1 | High write strobe, active low, used only when `strobe_lanes` is 1 |
| bhe_n | input | 1 | Upper lane enable in the address-bit lane scheme |
| wide | input | 1 | 1 selects a 16-bit processor bus |
| strobe_lanes | input | 1 | 1 selects lanes by separate write strobes |
| swap | input | 1 | Reverses the bus byte order in wide mode |
| addr | input | 15 | Processor byte address |
| wdata | input | 16 | Processor write data |
| dout | output | 16 | Processor read data |
| wait_n | output | 1 | Stall request to the processor, active low |
| disp_active | input | 1 | 1 while line data is being transferred |
| disp_upper | input | 1 | Selects the upper screen of a dual-scan panel |
| disp_word | input | 14 | Display word offset within the screen |
| disp_data | output | 16 | Fetched display word |
| disp_valid | output | 1 | `disp_data` is valid |
| cse | output | 1 | Current tick is taken by the display |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 2 | Per-lane RAM write enables |
| ram_addr | output | 14 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one tick after enable |

## Verification
The bench runs the same kinds of access in blanking and in active display. Blanking accesses must never pull `wait_n` low, while active-display accesses must, which separates the two arbitration regimes. A request placed just ahead of a display tick shows that the request is held back by exactly one tick. A free-running active window shows that the display and processor ticks strictly alternate. Byte-lane cases are written with one setting and read back with another: narrow writes are read wide, address-bit lanes are compared with strobe lanes, and swapped writes are read narrow. This exposes any lane or swap mix-up that a symmetric round trip would hide. Accesses at 4AFFh and 4B00h mark the edge of the storable range, and a word written at byte 2580h is fetched through the upper-screen offset.

// File: rtl/vram_slot_arbiter.sv
module vram_slot_arbiter #(
  parameter int AW = 15,
  parameter int DW = 16,
  parameter logic [AW-1:0] TOP_ADDR = 15'h4AFF,
  parameter int SCREEN2_WORD = 4800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mcs_n,
  input  logic          rd_n,
  input  logic          lwr_n,
  input  logic          hwr_n,
  input  logic          bhe_n,
  input  logic          wide,
  input  logic          strobe_lanes,
  input  logic          swap,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout,
  output logic          wait_n,
  input  logic          disp_active,
  input  logic          disp_upper,
  input  logic [AW-2:0] disp_word,
  output logic [DW-1:0] disp_data,
  output logic          disp_valid,
  output logic          cse,
  output logic          ram_en,
  output logic [1:0]    ram_we,
  output logic [AW-2:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam int HB = DW / 2;
  localparam int WW = AW - 1;

  logic slot, served, done, grant_q, fetch_q;
  logic [DW-1:0] rdata_q;

  wire is_rd    = !rd_n;
  wire wr_lo    = !lwr_n;
  wire wr_hi    = wide && strobe_lanes && !hwr_n;
  wire cpu_req  = !mcs_n && (is_rd || wr_lo || wr_hi);
  wire in_range = addr <= TOP_ADDR;
  wire grant    = cpu_req && in_range && !served && (!disp_active || !slot);

  assign cse = disp_active && slot;

  logic [1:0] be;
  always_comb begin
    if (!wide)             be = addr[0] ? {wr_lo, 1'b0} : {1'b0, wr_lo};
    else if (strobe_lanes) be = {wr_hi, wr_lo};
    else                   be = {!bhe_n, !addr[0]} & {2{wr_lo}};
  end

  wire [HB-1:0] lo_src = (wide && swap) ? wdata[DW-1:HB] : wdata[HB-1:0];
  wire [HB-1:0] hi_src = !wide ? wdata[HB-1:0] : (swap ? wdata[HB-1:0] : wdata[DW-1:HB]);

  assign ram_en    = grant || cse;
  assign ram_we    = (grant && !is_rd) ? be : 2'b00;
  assign ram_wdata = {hi_src, lo_src};
  assign ram_addr  = cse ? disp_word + (disp_upper ? WW'(SCREEN2_WORD) : '0) : addr[AW-1:1];

  logic [DW-1:0] rd_arr;
  always_comb begin
    if (!wide)     rd_arr = {{HB{1'b0}}, addr[0] ? ram_rdata[DW-1:HB] : ram_rdata[HB-1:0]};
    else if (swap) rd_arr = {ram_rdata[HB-1:0], ram_rdata[DW-1:HB]};
    else           rd_arr = ram_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot    <= 1'b0;
      served  <= 1'b0;
      done    <= 1'b0;
      grant_q <= 1'b0;
      fetch_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      slot    <= !slot;
      grant_q <= grant;
      fetch_q <= cse;
      served  <= cpu_req && (served || grant);
      done    <= cpu_req && (done || grant_q);
      if (grant_q && is_rd) rdata_q <= rd_arr;
    end
  end

  assign dout       = (!mcs_n && is_rd && in_range && done) ? rdata_q : '0;
  assign wait_n     = !(cpu_req && in_range && !done && disp_active);
  assign disp_data  = ram_rdata;
  assign disp_valid = fetch_q;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (wait_n && !cse && !grant_q));
  p_disp_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cse |-> (ram_en && ram_we == 2'b00));
  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_active && cse) |=> !cse);
  p_next_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cse && cpu_req && in_range && !served) |=> (!cpu_req || !disp_active || (ram_en && !cse)));
  p_blank_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_active && cpu_req && in_range && !served) |-> ram_en);
  p_out_of_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !in_range) |-> (wait_n && dout == '0 && ram_we == 2'b00));
  p_idle_bus_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || mcs_n) |-> dout == '0);
  p_fetch_valid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cse |=> disp_valid);
endmodule

// File: tb/tb_vram_slot_arbiter.sv
module tb_vram_slot_arbiter;
  logic clk = 0, rst_n = 0;
  logic mcs_n = 1, rd_n = 1, lwr_n = 1, hwr_n = 1, bhe_n = 1;
  logic wide = 0, strobe_lanes = 0, swap = 0;
  logic [14:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] dout, disp_data, ram_wdata, ram_rdata;
  logic wait_n, disp_active = 0, disp_upper = 0, disp_valid, cse, ram_en;
  logic [13:0] disp_word = '0, ram_addr;
  logic [1:0] ram_we;
  int checks = 0, errors = 0;
  logic we_seen;
  logic [15:0] mem [0:9599];

  always #10 clk = ~clk;

  vram_slot_arbiter dut (.*);

  initial begin
    for (int i = 0; i < 9600; i++) mem[i] = '0;
    ram_rdata = '0;
  end

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we[0]) mem[ram_addr][7:0]  <= ram_wdata[7:0];
      if (ram_we[1]) mem[ram_addr][15:8] <= ram_wdata[15:8];
      ram_rdata <= mem[ram_addr];
      if (|ram_we) we_seen <= 1'b1;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 read, 1 low strobe, 2 high strobe, 3 both strobes
  task automatic access(input logic w, input logic sl, input logic sw, input logic [14:0] a,
                        input logic bhe, input int kind, input logic [15:0] wd,
                        output logic [15:0] rd, output logic waited, output logic wrote);
    int n = 0;
    @(negedge clk);
    we_seen = 1'b0;
    wide = w; strobe_lanes = sl; swap = sw; addr = a; bhe_n = bhe; wdata = wd;
    mcs_n = 0;
    rd_n = (kind != 0);
    lwr_n = !(kind == 1 || kind == 3);
    hwr_n = !(kind == 2 || kind == 3);
    #1 waited = !wait_n;
    do begin
      @(negedge clk);
      n++;
      if (!wait_n) waited = 1'b1;
    end while ((n < 3 || !wait_n) && n < 30);
    rd = dout;
    if (kind == 0) begin
      @(negedge clk);
      check("R12 held", dout, rd);
    end
    mcs_n = 1; rd_n = 1; lwr_n = 1; hwr_n = 1; bhe_n = 1;
    #1 check("R12 released", dout, 16'h0);
    wrote = we_seen;
  endtask

  logic [15:0] r;
  logic wt, wr;

  task automatic t_reset;
    @(negedge clk);
    check("R1 wait_n", {15'd0, wait_n}, 16'd1);
    check("R1 cse", {15'd0, cse}, 16'd0);
    check("R1 ram_en", {15'd0, ram_en}, 16'd0);
    check("R1 dout", dout, 16'h0);
  endtask

  task automatic t_blank;
    disp_active = 0;
    access(0, 0, 0, 15'h0003, 1, 1, 16'h005A, r, wt, wr);
    check("R5 no wait on write", {15'd0, wt}, 16'd0);
    access(0, 0, 0, 15'h0003, 1, 0, 16'h0, r, wt, wr);
    check("R7 odd byte read", r, 16'h005A);
    check("R5 no wait on read", {15'd0, wt}, 16'd0);
    access(1, 0, 0, 15'h0002, 1, 0, 16'h0, r, wt, wr);
    check("R7 odd byte in upper lane", r, 16'h5A00);
  endtask

  task automatic t_active;
    disp_active = 1;
    access(1, 0, 0, 15'h0040, 0, 1, 16'hBEEF, r, wt, wr);
    check("R4 wait on write", {15'd0, wt}, 16'd1);
    access(1, 0, 0, 15'h0040, 1, 0, 16'h0, r, wt, wr);
    check("R4 wait on read", {15'd0, wt}, 16'd1);
    check("R4 read data after wait", r, 16'hBEEF);
    check("R4 wait released", {15'd0, wait_n}, 16'd1);
    disp_active = 0;
  endtask

  task automatic t_slots;
    logic prev;
    disp_word = 14'd5; disp_upper = 0;
    @(negedge clk);
    disp_active = 1;
    #1 prev = cse;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R2 alternation", {15'd0, cse}, {15'd0, !prev});
      if (cse) begin
        check("R2 display tick enable", {14'd0, ram_en, ram_we == 2'b00}, 16'd3);
        check("R2 display address", {2'd0, ram_addr}, 16'd5);
      end
      prev = cse;
    end
    while (!cse) @(negedge clk);
    wide = 0; addr = 15'h0041; mcs_n = 0; rd_n = 0;
    #1 check("R3 wait before service", {15'd0, wait_n}, 16'd0);
    @(negedge clk);
    check("R3 served next cpu tick", {14'd0, ram_en, cse}, 16'd2);
    check("R3 cpu address", {2'd0, ram_addr}, 16'h0020);
    @(negedge clk);
    @(negedge clk);
    check("R3 read data", dout, 16'h00BE);
    mcs_n = 1; rd_n = 1;
    disp_active = 0;
  endtask

  task automatic t_dual;
    disp_active = 0;
    access(1, 0, 0, 15'h2580, 0, 1, 16'hC0DE, r, wt, wr);
    disp_upper = 1; disp_word = 0;
    @(negedge clk);
    disp_active = 1;
    @(negedge clk);
    while (!cse) @(negedge clk);
    check("R11 upper screen address", {2'd0, ram_addr}, 16'd4800);
    @(negedge clk);
    check("R13 valid", {15'd0, disp_valid}, 16'd1);
    check("R13 data", disp_data, 16'hC0DE);
    disp_active = 0; disp_upper = 0;
  endtask

  task automatic t_range;
    disp_active = 1;
    access(0, 0, 0, 15'h4B00, 1, 1, 16'h00FF, r, wt, wr);
    check("R6 no write", {15'd0, wr}, 16'd0);
    check("R6 no wait on write", {15'd0, wt}, 16'd0);
    access(0, 0, 0, 15'h4B00, 1, 0, 16'h0, r, wt, wr);
    check("R6 read zero", r, 16'h0);
    check("R6 no wait on read", {15'd0, wt}, 16'd0);
    access(0, 0, 0, 15'h4AFF, 1, 1, 16'h0077, r, wt, wr);
    access(0, 0, 0, 15'h4AFF, 1, 0, 16'h0, r, wt, wr);
    check("R6 top byte stored", r, 16'h0077);
    disp_active = 0;
  endtask

  task automatic t_lanes;
    access(1, 0, 0, 15'h0021, 0, 1, 16'hAB00, r, wt, wr);
    access(0, 0, 0, 15'h0021, 1, 0, 16'h0, r, wt, wr);
    check("R8 upper lane by bhe", r, 16'h00AB);
    access(0, 0, 0, 15'h0020, 1, 0, 16'h0, r, wt, wr);
    check("R8 lower lane untouched", r, 16'h0000);
    access(1, 0, 0, 15'h0030, 1, 1, 16'h1155, r, wt, wr);
    access(1, 0, 0, 15'h0030, 1, 0, 16'h0, r, wt, wr);
    check("R8 lower lane only", r, 16'h0055);
    access(1, 1, 0, 15'h0050, 1, 2, 16'h6699, r, wt, wr);
    access(1, 0, 0, 15'h0050, 1, 0, 16'h0, r, wt, wr);
    check("R9 high strobe lane", r, 16'h6600);
    access(1, 1, 0, 15'h0050, 1, 1, 16'h2244, r, wt, wr);
    access(1, 0, 0, 15'h0050, 1, 0, 16'h0, r, wt, wr);
    check("R9 low strobe lane", r, 16'h6644);
  endtask

  task automatic t_swap;
    disp_active = 1;
    access(1, 0, 1, 15'h0060, 0, 1, 16'h1234, r, wt, wr);
    disp_active = 0;
    access(0, 0, 0, 15'h0060, 1, 0, 16'h0, r, wt, wr);
    check("R10 even byte from upper bus", r, 16'h0012);
    access(0, 0, 0, 15'h0061, 1, 0, 16'h0, r, wt, wr);
    check("R10 odd byte from lower bus", r, 16'h0034);
    access(1, 0, 1, 15'h0060, 1, 0, 16'h0, r, wt, wr);
    check("R10 swapped read", r, 16'h1234);
    access(1, 0, 0, 15'h0060, 1, 0, 16'h0, r, wt, wr);
    check("R10 straight read", r, 16'h3412);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_blank();
    t_active();
    t_slots();
    t_dual();
    t_range();
    t_lanes();
    t_swap();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule